// File: doc/BRIEF.md
# Generation-Tag Barrier Checker

This block screens memory operations against three software-programmed masks so that a garbage collector can catch cross-generation references without extra barrier instructions in the program. Every 64-bit address and pointer carries a 3-bit generation tag in its top bits. When a request arrives, the block reads the tag of the target address. For a pointer-store it also reads the tag of the pointer value being written. It then looks up one mask bit and reports a trap, with the cause, one cycle later.

Loads and ordinary stores each have their own 8-bit mask, indexed by the address tag alone. A pointer-store joins the address tag and the stored-pointer tag into a 6-bit index into a 64-bit mask. Ordinary stores never consult that mask. The application writes the masks through a plain register-write port.

The request side has a valid strobe and no ready: the block accepts one request on every cycle and never applies back-pressure. The trap and cause outputs are plain registered status. The block does no memory access and does no trap handling.

Top module: `gcb_barrier`

## Requirements
- R1: After reset all three masks are zero: trap_o and cause_o read 0, and no request traps until a mask bit is set.
- R2: A load (req_op 01) traps when the load-mask bit indexed by address bits [63:61] is 1; its cause is 01.
- R3: A store (req_op 10) traps when the store-mask bit indexed by address bits [63:61] is 1; its cause is 10.
- R4: A pointer-store (req_op 11) traps when bit {address[63:61], data[63:61]} of the 64-bit pointer mask is 1, with the address tag as the upper three index bits; its cause is 11.
- R5: Each operation consults only its own mask. A pointer-store ignores the store mask, and a store ignores the pointer mask.
- R6: trap_o and cause_o are registered one cycle after the request. A cycle with req_valid low or req_op 00 yields trap_o 0 and cause_o 00 on the next cycle, and cause_o is 00 whenever trap_o is 0.
- R7: A mask write takes effect on the following cycle. A request in the same cycle as the write is checked against the old mask.
- R8: cfg_sel selects the target (01 load mask, 10 store mask, 11 pointer mask). A write with cfg_sel 00 changes nothing. The 8-bit masks take cfg_wdata[7:0].
- R9: Address and data bits below the tag field have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted every cycle |
| req_op | input | 2 | 00 none, 01 load, 10 store, 11 pointer-store |
| req_addr | input | 64 | Target address; tag in [63:61] |
| req_data | input | 64 | Pointer value being stored; tag in [63:61] |
| cfg_we | input | 1 | Mask write enable |
| cfg_sel | input | 2 | Mask select: 01 load, 10 store, 11 pointer, 00 none |
| cfg_wdata | input | 64 | Mask write value |
| trap_o | output | 1 | Registered trap flag |
| cause_o | output | 2 | Registered trap cause, same code as req_op |

## Verification
The bench builds the block with its default parameters: 64-bit pointers and a 3-bit tag. With those values the two 8-bit masks and the full 64-bit pointer mask are in play. The vector table can therefore reach both orderings of the two tags in the 6-bit pointer-store index, and show that swapping them changes the outcome. The filler bits below the tag vary from vector to vector. This confirms that only bits [63:61] drive the lookup.

// File: rtl/gcb_pkg.sv
package gcb_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOAD   = 2'b01,
    OP_STORE  = 2'b10,
    OP_PSTORE = 2'b11
  } gcb_op_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_LOAD  = 2'b01,
    SEL_STORE = 2'b10,
    SEL_PTR   = 2'b11
  } gcb_sel_e;
endpackage

// File: rtl/gcb_tag_extract.sv
module gcb_tag_extract #(
  parameter int PTR_W = 64,
  parameter int TAG_W = 3
) (
  input  logic [PTR_W-1:0] ptr_i,
  output logic [TAG_W-1:0] tag_o
);
  localparam int LOW_W = PTR_W - TAG_W;

  logic unused_low;

  assign tag_o      = ptr_i[PTR_W-1 -: TAG_W];
  assign unused_low = ^ptr_i[LOW_W-1:0];
endmodule

// File: rtl/gcb_mask_bank.sv
module gcb_mask_bank
  import gcb_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [1:0]                   sel_i,
  input  logic [(1<<(2*TAG_W))-1:0]    wdata_i,
  output logic [(1<<TAG_W)-1:0]        ld_mask_o,
  output logic [(1<<TAG_W)-1:0]        st_mask_o,
  output logic [(1<<(2*TAG_W))-1:0]    ps_mask_o
);
  localparam int SM_W = 1 << TAG_W;
  localparam int PM_W = 1 << (2*TAG_W);

  gcb_sel_e sel;
  assign sel = gcb_sel_e'(sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_mask_o <= '0;
      st_mask_o <= '0;
      ps_mask_o <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_LOAD:  ld_mask_o <= wdata_i[SM_W-1:0];
        SEL_STORE: st_mask_o <= wdata_i[SM_W-1:0];
        SEL_PTR:   ps_mask_o <= wdata_i[PM_W-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gcb_trap_lookup.sv
module gcb_trap_lookup
  import gcb_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic                      valid_i,
  input  logic [1:0]                op_i,
  input  logic [TAG_W-1:0]          atag_i,
  input  logic [TAG_W-1:0]          dtag_i,
  input  logic [(1<<TAG_W)-1:0]     ld_mask_i,
  input  logic [(1<<TAG_W)-1:0]     st_mask_i,
  input  logic [(1<<(2*TAG_W))-1:0] ps_mask_i,
  output logic                      hit_o,
  output logic [1:0]                cause_o
);
  localparam int IDX_W = 2 * TAG_W;

  logic [IDX_W-1:0] ps_idx;
  logic             ld_bit, st_bit, ps_bit;
  gcb_op_e          op;

  assign op     = gcb_op_e'(op_i);
  assign ps_idx = {atag_i, dtag_i};
  assign ld_bit = ld_mask_i[atag_i];
  assign st_bit = st_mask_i[atag_i];
  assign ps_bit = ps_mask_i[ps_idx];

  always_comb begin
    hit_o = 1'b0;
    if (valid_i) begin
      case (op)
        OP_LOAD:   hit_o = ld_bit;
        OP_STORE:  hit_o = st_bit;
        OP_PSTORE: hit_o = ps_bit;
        default:   hit_o = 1'b0;
      endcase
    end
    cause_o = hit_o ? op_i : 2'b00;
  end
endmodule

// File: rtl/gcb_barrier.sv
module gcb_barrier #(
  parameter int PTR_W = 64,
  parameter int TAG_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [1:0]                req_op,
  input  logic [PTR_W-1:0]          req_addr,
  input  logic [PTR_W-1:0]          req_data,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [(1<<(2*TAG_W))-1:0] cfg_wdata,
  output logic                      trap_o,
  output logic [1:0]                cause_o
);
  localparam int SM_W = 1 << TAG_W;
  localparam int PM_W = 1 << (2*TAG_W);

  logic [TAG_W-1:0] atag, dtag;
  logic [SM_W-1:0]  ld_mask, st_mask;
  logic [PM_W-1:0]  ps_mask;
  logic             hit;
  logic [1:0]       cause_d;

  gcb_tag_extract #(.PTR_W(PTR_W), .TAG_W(TAG_W)) u_atag (
    .ptr_i (req_addr),
    .tag_o (atag)
  );

  gcb_tag_extract #(.PTR_W(PTR_W), .TAG_W(TAG_W)) u_dtag (
    .ptr_i (req_data),
    .tag_o (dtag)
  );

  gcb_mask_bank #(.TAG_W(TAG_W)) u_masks (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we),
    .sel_i     (cfg_sel),
    .wdata_i   (cfg_wdata),
    .ld_mask_o (ld_mask),
    .st_mask_o (st_mask),
    .ps_mask_o (ps_mask)
  );

  gcb_trap_lookup #(.TAG_W(TAG_W)) u_lookup (
    .valid_i   (req_valid),
    .op_i      (req_op),
    .atag_i    (atag),
    .dtag_i    (dtag),
    .ld_mask_i (ld_mask),
    .st_mask_i (st_mask),
    .ps_mask_i (ps_mask),
    .hit_o     (hit),
    .cause_o   (cause_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_o  <= 1'b0;
      cause_o <= 2'b00;
    end else begin
      trap_o  <= hit;
      cause_o <= cause_d;
    end
  end
endmodule

// File: rtl/gcb_barrier_chk.sv
module gcb_barrier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       cfg_we,
  input logic [1:0] cfg_sel,
  input logic       trap_o,
  input logic [1:0] cause_o
);
  logic seen_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen_wr <= 1'b0;
    else if (cfg_we && cfg_sel != 2'b00) seen_wr <= 1'b1;
  end

  AST_NO_TRAP_BEFORE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_wr && req_valid) |=> !trap_o) else $error("no trap expected"); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op == 2'b00) |=> (!trap_o && cause_o == 2'b00)) else $error("idle trap"); // R6

  AST_CAUSE_IS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'b00) |=> (!trap_o || cause_o == $past(req_op))) else $error("cause"); // R4

  AST_CAUSE_ZERO_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> cause_o == 2'b00) else $error("stray cause"); // R6

  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> cause_o != 2'b00) else $error("empty cause"); // R2
endmodule

bind gcb_barrier gcb_barrier_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .trap_o    (trap_o),
  .cause_o   (cause_o)
);

// File: tb/gcb_barrier_tb.sv
module gcb_barrier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [63:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'b00;
  logic [63:0] cfg_wdata = '0;
  logic        trap_o;
  logic [1:0]  cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gcb_barrier u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .trap_o(trap_o), .cause_o(cause_o)
  );

  // {op[10:9], atag[8:6], dtag[5:3], exp_trap[2], exp_cause[1:0]}
  // masks: load 8'hA5, store 8'h48, pointer 64'h0100_0000_2000_0001
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    {2'b01, 3'd0, 3'd0, 1'b1, 2'b01},  // R2
    {2'b01, 3'd1, 3'd6, 1'b0, 2'b00},  // R2
    {2'b01, 3'd7, 3'd0, 1'b1, 2'b01},  // R2
    {2'b01, 3'd3, 3'd0, 1'b0, 2'b00},  // R5 store bit 3 not used by load
    {2'b10, 3'd3, 3'd0, 1'b1, 2'b10},  // R3
    {2'b10, 3'd6, 3'd0, 1'b1, 2'b10},  // R3
    {2'b10, 3'd0, 3'd0, 1'b0, 2'b00},  // R5 pointer bit 0 not used by store
    {2'b11, 3'd3, 3'd5, 1'b1, 2'b11},  // R4 index 29
    {2'b11, 3'd5, 3'd3, 1'b0, 2'b00},  // R4 swapped order
    {2'b11, 3'd7, 3'd0, 1'b1, 2'b11},  // R4 index 56
    {2'b11, 3'd0, 3'd0, 1'b1, 2'b11},  // R4 index 0
    {2'b11, 3'd0, 3'd1, 1'b0, 2'b00},  // R4
    {2'b11, 3'd6, 3'd0, 1'b0, 2'b00},  // R5 store mask bit 6 ignored
    {2'b11, 3'd3, 3'd0, 1'b0, 2'b00},  // R5 store mask bit 3 ignored
    {2'b00, 3'd0, 3'd0, 1'b0, 2'b00}   // R6 op none
  };

  task automatic check_out(input string req, input logic et, input logic [1:0] ec);
    checks++;
    if (trap_o !== et || cause_o !== ec) begin
      errors++;
      $display("FAIL %s: trap=%0b cause=%0d expected trap=%0b cause=%0d",
               req, trap_o, cause_o, et, ec);
    end
  endtask

  task automatic wr_mask(input logic [1:0] sel, input logic [63:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'b00;
  endtask

  task automatic do_req(input logic v, input logic [1:0] op, input logic [2:0] at,
                        input logic [2:0] dt, input logic [60:0] fill,
                        input string req, input logic et, input logic [1:0] ec);
    @(negedge clk);
    req_valid = v; req_op = op;
    req_addr = {at, fill}; req_data = {dt, ~fill};
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00;
    check_out(req, et, ec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out("R1 reset", 1'b0, 2'b00);
    rst_n = 1'b1;
    for (int t = 0; t < 8; t++) begin
      do_req(1'b1, 2'b01, 3'(t), 3'(t), 61'(t * 977), "R1 load zero mask", 1'b0, 2'b00);
      do_req(1'b1, 2'b11, 3'(t), 3'(7 - t), 61'(t), "R1 pstore zero mask", 1'b0, 2'b00);
    end

    wr_mask(2'b01, 64'hFFFF_FFFF_FFFF_FF00);  // R8 upper bits dropped
    do_req(1'b1, 2'b01, 3'd0, 3'd0, 61'h5, "R8 low byte only", 1'b0, 2'b00);

    wr_mask(2'b01, 64'h0000_0000_0000_00A5);
    wr_mask(2'b10, 64'h0000_0000_0000_0048);
    wr_mask(2'b11, 64'h0100_0000_2000_0001);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      do_req(1'b1, v[10:9], v[8:6], v[5:3], 61'h0ABC_1234_5678 ^ 61'(i * 61'h1_0F0F_3791),
             "R2/R3/R4/R5 vector", v[2], v[1:0]);
    end

    // R6: valid low while op would trap
    do_req(1'b0, 2'b01, 3'd0, 3'd0, 61'h1, "R6 valid low", 1'b0, 2'b00);

    // R9: extreme filler patterns
    do_req(1'b1, 2'b01, 3'd1, 3'd0, '1, "R9 filler ones", 1'b0, 2'b00);
    do_req(1'b1, 2'b01, 3'd2, 3'd0, '0, "R9 filler zeros", 1'b1, 2'b01);

    // R8: select 00 write changes nothing
    wr_mask(2'b00, 64'hFFFF_FFFF_FFFF_FFFF);
    do_req(1'b1, 2'b10, 3'd0, 3'd0, 61'h7, "R8 sel none store", 1'b0, 2'b00);
    do_req(1'b1, 2'b11, 3'd0, 3'd1, 61'h7, "R8 sel none pstore", 1'b0, 2'b00);
    do_req(1'b1, 2'b01, 3'd1, 3'd0, 61'h7, "R8 sel none load", 1'b0, 2'b00);

    // R7: write and check in the same cycle uses the old mask
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'b01; cfg_wdata = 64'h0000_0000_0000_0002;
    req_valid = 1'b1; req_op = 2'b01; req_addr = {3'd1, 61'h99};
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'b00;
    check_out("R7 same cycle old mask", 1'b0, 2'b00);
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00;
    check_out("R7 next cycle new mask", 1'b1, 2'b01);
    do_req(1'b1, 2'b01, 3'd0, 3'd0, 61'h3, "R7 old bit cleared", 1'b0, 2'b00);

    // R6: outputs drop one cycle after the trap
    @(negedge clk);
    check_out("R6 quiet after trap", 1'b0, 2'b00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule